// File: doc/BRIEF.md
# Paired Event Counter Unit

This block is a performance monitoring unit. Eight 32-bit event counters are grouped into four pairs, and each pair has a lower and an upper member. Software reaches the block through two 64-bit registers. The control register holds the mode enables, the event codes, a pair-select field and the overflow flags. The counter-data register shows one pair at a time: the upper counter sits in the high word and the lower counter in the low word.

Each counter chooses one of 64 event lines with a 6-bit code. Code 0 is a constant-high cycle event. Code 1 is the instruction-retire input. Codes 2 to 63 pick lines from an external event vector. Counting is gated by the current privilege level: the system-mode enable applies while `priv_mode` is high, and the user-mode enable applies while it is low. Two guard bits in each control write decide whether that write also changes the event codes and whether it also changes the overflow flags. This lets software update the other fields without disturbing either one. Interrupt delivery and the event sources themselves lie outside this block.

Top module: `evctr_unit`

## Requirements
- R1: After reset, all counters, event codes, enables, guard bits, overflow flags and the pair select are zero. The control register then reads 0x0000_0000_01C0_0000 and the data register reads zero.
- R2: Control read layout: bit 0 privileged flag, bit 1 system enable, bit 2 user enable, bit 3 event guard, bits 9:4 lower code of the selected pair, bits 16:11 upper code, bits 20:18 pair select, bits 24:22 read-only counter count minus one (7), bit 26 overflow guard, bits 39:32 overflow flags. Every other bit reads zero.
- R3: A control write with bit 3 set loads bits 9:4 and 16:11 into the codes of the pair named by its own bits 20:18. With bit 3 clear, no code changes.
- R4: A control write with bit 26 set loads the overflow flags from bits 39:32. With bit 26 clear, the flags are unchanged.
- R5: The data register reads and writes only the selected pair: upper counter (index 2p+1) in bits 63:32 and lower counter (index 2p) in bits 31:0. A select value of 4 or more reads zero, ignores data writes, and shows zero codes.
- R6: In each enabled cycle, a counter adds one when its chosen event line is high. Code 0 is always high, code 1 is `insn_retire`, and code k (k ≥ 2) is `ev_ext[k-2]`.
- R7: A counter counts only when (`priv_mode` and the system enable) or (not `priv_mode` and the user enable) holds.
- R8: A counter that wraps from 0xFFFFFFFF to 0 sets the flag at bit 32 plus its index. The flag stays set until a guarded control write clears it.
- R9: A data write in the same cycle as an increment wins. The counter takes the written value, and no overflow flag is set.
- R10: The read data outputs are registered. They show a register change one clock after the edge that made it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 64 | Control register write data |
| ctl_rdata | output | 64 | Control register read data (registered) |
| dat_we | input | 1 | Counter-data register write strobe |
| dat_wdata | input | 64 | Counter-data write data, upper counter in high word |
| dat_rdata | output | 64 | Counter-data read data for the selected pair (registered) |
| priv_mode | input | 1 | High while the processor runs in system mode |
| insn_retire | input | 1 | Instruction-retire event (code 1) |
| ev_ext | input | 62 | External events for codes 2 to 63 |

## Verification
The bench builds the unit with its default of four pairs. That is small enough to sweep all 64 event codes on the lower and upper counter of every pair, under an event pattern and under its complement, and to compare each count with the window length multiplied by the expected event bit. It also runs all eight combinations of system enable, user enable and privilege level. Directed sequences cover wrap and flag stickiness, both guard bits set and clear, out-of-range pair selects, and a data write landing on the same edge as an increment or a wrap.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  localparam int REG_W  = 64;
  localparam int CNT_W  = REG_W / 2;
  localparam int CODE_W = 6;
  localparam int SEL_W  = 3;
  localparam int NC_W   = 3;
  localparam int EV_N   = 1 << CODE_W;
  localparam int EXT_N  = EV_N - 2;

  // control register bit positions (software-visible layout)
  localparam int PRIV_B = 0;
  localparam int SYS_B  = 1;
  localparam int USR_B  = 2;
  localparam int EVG_B  = 3;
  localparam int LO_B   = 4;
  localparam int HI_B   = 11;
  localparam int SEL_B  = 18;
  localparam int NC_B   = 22;
  localparam int OVG_B  = 26;
  localparam int OVF_B  = 32;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/evctr_ctl.sv
module evctr_ctl
  import evctr_pkg::*;
#(
  parameter int NUM_CTR = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [REG_W-1:0]               wdata,
  input  logic [NUM_CTR-1:0]             ovf_set,
  output logic [3:0]                     flags,
  output logic [SEL_W-1:0]               sel,
  output logic                           ovg,
  output logic [NUM_CTR-1:0][CODE_W-1:0] codes,
  output logic [NUM_CTR-1:0]             ovf
);
  localparam int NUM_PAIRS = NUM_CTR / 2;

  logic [SEL_W-1:0] wsel;
  logic             code_load;
  logic             ovf_load;
  logic             unused_wbits;

  assign wsel      = wdata[SEL_B +: SEL_W];
  assign code_load = we && wdata[EVG_B];
  assign ovf_load  = we && wdata[OVG_B];
  assign unused_wbits = ^{wdata[HI_B-1 -: 1], wdata[SEL_B-1 -: 1],
                          wdata[OVG_B-1:SEL_B+SEL_W], wdata[OVF_B-1:OVG_B+1],
                          wdata[REG_W-1:OVF_B+NUM_CTR]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      sel   <= '0;
      ovg   <= 1'b0;
    end else if (we) begin
      flags <= wdata[3:0];
      sel   <= wsel;
      ovg   <= wdata[OVG_B];
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_code
    always_ff @(posedge clk) begin
      if (rst) begin
        codes[2*p]   <= '0;
        codes[2*p+1] <= '0;
      end else if (code_load && wsel == SEL_W'(p)) begin
        codes[2*p]   <= wdata[LO_B +: CODE_W];
        codes[2*p+1] <= wdata[HI_B +: CODE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           ovf <= '0;
    else if (ovf_load) ovf <= wdata[OVF_B +: NUM_CTR];
    else               ovf <= ovf | ovf_set;
  end

  // R3: unguarded writes leave every event code alone
  p_evt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !code_load |=> $stable(codes));

  // R4, R8: flags only fall through a guarded write
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !ovf_load |=> ((ovf & $past(ovf)) == $past(ovf)));

  // R8: a wrap raises its flag on the same edge
  p_wrap_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (|ovf_set) && !ovf_load |=> ((ovf & $past(ovf_set)) == $past(ovf_set)));
endmodule

// File: rtl/evctr_counter.sv
module evctr_counter
  import evctr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  code_t           code,
  input  logic [EV_N-1:0] ev_all,
  input  logic            mode_ok,
  input  logic            wr,
  input  cnt_t            wval,
  output cnt_t            cnt,
  output logic            wrap
);
  logic hit;

  assign hit  = ev_all[code] && mode_ok;
  assign wrap = hit && !wr && (&cnt);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (wr)  cnt <= wval;
    else if (hit) cnt <= cnt + cnt_t'(1);
  end

  // R9: software write takes the slot
  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt == $past(wval)));

  // R6: without a write the counter holds or steps by one
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + cnt_t'(1))));
endmodule

// File: rtl/evctr_rdmux.sv
module evctr_rdmux
  import evctr_pkg::*;
#(
  parameter int NUM_CTR = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [3:0]                     flags,
  input  logic [SEL_W-1:0]               sel,
  input  logic                           ovg,
  input  logic [NUM_CTR-1:0][CODE_W-1:0] codes,
  input  logic [NUM_CTR-1:0]             ovf,
  input  logic [NUM_CTR-1:0][CNT_W-1:0]  cnts,
  output logic [REG_W-1:0]               ctl_rdata,
  output logic [REG_W-1:0]               dat_rdata
);
  localparam int NUM_PAIRS = NUM_CTR / 2;
  localparam logic [NC_W-1:0] NC_VAL = NC_W'(NUM_CTR - 1);

  logic [REG_W-1:0] ctl_n;
  logic [REG_W-1:0] dat_n;

  always_comb begin
    ctl_n = '0;
    dat_n = '0;
    ctl_n[3:0]                 = flags;
    ctl_n[SEL_B +: SEL_W]      = sel;
    ctl_n[NC_B +: NC_W]        = NC_VAL;
    ctl_n[OVG_B]               = ovg;
    ctl_n[OVF_B +: NUM_CTR]    = ovf;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (sel == SEL_W'(p)) begin
        ctl_n[LO_B +: CODE_W] = codes[2*p];
        ctl_n[HI_B +: CODE_W] = codes[2*p+1];
        dat_n = {cnts[2*p+1], cnts[2*p]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rdata <= REG_W'(NC_VAL) << NC_B;
      dat_rdata <= '0;
    end else begin
      ctl_rdata <= ctl_n;
      dat_rdata <= dat_n;
    end
  end
endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
  import evctr_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  input  logic             dat_we,
  input  logic [REG_W-1:0] dat_wdata,
  output logic [REG_W-1:0] dat_rdata,
  input  logic             priv_mode,
  input  logic             insn_retire,
  input  logic [EXT_N-1:0] ev_ext
);
  localparam int NUM_CTR = 2 * NUM_PAIRS;

  logic [3:0]                     flags;
  logic [SEL_W-1:0]               sel;
  logic                           ovg;
  logic [NUM_CTR-1:0][CODE_W-1:0] codes;
  logic [NUM_CTR-1:0]             ovf;
  logic [NUM_CTR-1:0]             wrap;
  logic [NUM_CTR-1:0][CNT_W-1:0]  cnts;
  logic [EV_N-1:0]                ev_all;
  logic                           mode_ok;

  assign ev_all  = {ev_ext, insn_retire, 1'b1};
  assign mode_ok = priv_mode ? flags[SYS_B] : flags[USR_B];

  evctr_ctl #(.NUM_CTR(NUM_CTR)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .ovf_set(wrap),
    .flags(flags), .sel(sel), .ovg(ovg), .codes(codes), .ovf(ovf)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic pair_wr;
    assign pair_wr = dat_we && (sel == SEL_W'(p));

    evctr_counter u_lo (
      .clk(clk), .rst(rst), .code(codes[2*p]), .ev_all(ev_all),
      .mode_ok(mode_ok), .wr(pair_wr), .wval(dat_wdata[CNT_W-1:0]),
      .cnt(cnts[2*p]), .wrap(wrap[2*p])
    );
    evctr_counter u_hi (
      .clk(clk), .rst(rst), .code(codes[2*p+1]), .ev_all(ev_all),
      .mode_ok(mode_ok), .wr(pair_wr), .wval(dat_wdata[REG_W-1:CNT_W]),
      .cnt(cnts[2*p+1]), .wrap(wrap[2*p+1])
    );
  end

  evctr_rdmux #(.NUM_CTR(NUM_CTR)) u_rd (
    .clk(clk), .rst(rst), .flags(flags), .sel(sel), .ovg(ovg),
    .codes(codes), .ovf(ovf), .cnts(cnts),
    .ctl_rdata(ctl_rdata), .dat_rdata(dat_rdata)
  );

  // R2: the counter-count field never shows anything but its constant
  p_nc_field_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[NC_B +: NC_W] == NC_W'(NUM_CTR - 1));
endmodule

// File: tb/evctr_unit_bench.sv
`timescale 1ns/1ps
module evctr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [63:0] ctl_wdata = '0;
  logic [63:0] ctl_rdata;
  logic        dat_we = 1'b0;
  logic [63:0] dat_wdata = '0;
  logic [63:0] dat_rdata;
  logic        priv_mode = 1'b0;
  logic        insn_retire = 1'b0;
  logic [61:0] ev_ext = '0;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [3:0] m_flags = '0;
  logic [2:0] m_sel = '0;
  logic       m_ovg = 1'b0;
  logic [7:0] m_ovf = '0;
  logic [5:0] m_code [8];

  always #2.5 clk = ~clk;

  evctr_unit u_evctr_unit (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .priv_mode(priv_mode),
    .insn_retire(insn_retire), .ev_ext(ev_ext)
  );

  function automatic logic [63:0] mkctl(logic sy, logic us, logic eg,
      logic [5:0] lo, logic [5:0] hi, logic [2:0] sl, logic og, logic [7:0] ov);
    logic [63:0] v = '0;
    v[1] = sy; v[2] = us; v[3] = eg;
    v[9:4] = lo; v[16:11] = hi; v[20:18] = sl; v[26] = og; v[39:32] = ov;
    return v;
  endfunction

  function automatic logic [63:0] exp_ctl();
    logic [63:0] v = '0;
    v[3:0] = m_flags; v[20:18] = m_sel; v[24:22] = 3'd7;
    v[26] = m_ovg; v[39:32] = m_ovf;
    if (m_sel < 3'd4) begin
      v[9:4]   = m_code[2*m_sel];
      v[16:11] = m_code[2*m_sel+1];
    end
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(logic [63:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
    m_flags = v[3:0]; m_sel = v[20:18]; m_ovg = v[26];
    if (v[3] && v[20:18] < 3'd4) begin
      m_code[2*v[20:18]]   = v[9:4];
      m_code[2*v[20:18]+1] = v[16:11];
    end
    if (v[26]) m_ovf = v[39:32];
  endtask

  task automatic dat_wr(logic [63:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic priv_win(int n);
    @(negedge clk); priv_mode = 1'b1;
    repeat (n) @(negedge clk);
    priv_mode = 1'b0;
  endtask

  task automatic ev_win(int n, logic [61:0] bits);
    @(negedge clk); ev_ext = bits;
    repeat (n) @(negedge clk);
    ev_ext = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [63:0] old;
    logic [61:0] pat;
    for (int i = 0; i < 8; i++) m_code[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1: reset state
    check("R1 ctl", ctl_rdata, 64'h0000_0000_01C0_0000);
    check("R1 dat", dat_rdata, 64'h0);

    // R10: one-cycle read latency
    old = exp_ctl();
    ctl_wr(mkctl(0, 0, 1, 6'd5, 6'd9, 3'd1, 0, 8'h00));
    check("R10 old value still shown", ctl_rdata, old);
    settle();
    check("R10 new value", ctl_rdata, exp_ctl());

    // R2: every bit set, reserved bits and count field ignore writes
    ctl_wr('1);
    settle();
    check("R2 all-ones write", ctl_rdata, exp_ctl());
    check("R2 literal", ctl_rdata, 64'h0000_00FF_05DC_000F);

    // R4: overflow guard
    ctl_wr(mkctl(0, 0, 0, 0, 0, 3'd0, 0, 8'h00));
    settle();
    check("R4 unguarded keeps flags", ctl_rdata, exp_ctl());
    check("R4 flags FF", {56'h0, ctl_rdata[39:32]}, 64'hFF);
    ctl_wr(mkctl(0, 0, 0, 0, 0, 3'd0, 1, 8'h00));
    settle();
    check("R4 guarded clear", ctl_rdata, exp_ctl());
    ctl_wr(mkctl(0, 0, 0, 0, 0, 3'd0, 1, 8'hA5));
    settle();
    check("R4 guarded load A5", {56'h0, ctl_rdata[39:32]}, 64'hA5);
    ctl_wr(mkctl(0, 0, 0, 0, 0, 3'd0, 1, 8'h00));

    // R3: event guard
    ctl_wr(mkctl(0, 0, 1, 6'h11, 6'h22, 3'd2, 0, 8'h00));
    settle();
    check("R3 guarded load", ctl_rdata, exp_ctl());
    ctl_wr(mkctl(0, 0, 0, 6'h3F, 6'h3F, 3'd2, 0, 8'h00));
    settle();
    check("R3 unguarded keeps codes", ctl_rdata, exp_ctl());
    check("R3 codes literal", {50'h0, ctl_rdata[16:11], ctl_rdata[9:4]}, 64'h891);

    // R5: pair isolation
    for (int p = 0; p < 4; p++) begin
      ctl_wr(mkctl(0, 0, 0, 0, 0, 3'(p), 0, 8'h00));
      dat_wr({32'hA000_0000 + 32'(p), 32'h5000_0000 + 32'(p)});
    end
    ctl_wr(mkctl(0, 0, 0, 0, 0, 3'd5, 0, 8'h00));
    dat_wr('1);
    settle();
    check("R5 out-of-range sel reads zero", dat_rdata, 64'h0);
    for (int p = 0; p < 4; p++) begin
      ctl_wr(mkctl(0, 0, 0, 0, 0, 3'(p), 0, 8'h00));
      settle();
      check("R5 pair readback", dat_rdata,
            {32'hA000_0000 + 32'(p), 32'h5000_0000 + 32'(p)});
    end

    // R6: sweep every code on every pair under two patterns
    for (int k = 0; k < 2; k++) begin
      pat = (k == 0) ? 62'h2A5F0C3E9B7164D8 : ~62'h2A5F0C3E9B7164D8;
      ev_ext = pat;
      insn_retire = k[0];
      for (int p = 0; p < 4; p++) begin
        for (int c = 0; c < 64; c++) begin
          logic [63:0] eva;
          int h, n;
          logic [31:0] elo, ehi;
          h = (c + 17) % 64;
          n = 3 + p;
          eva = {pat, k[0], 1'b1};
          ctl_wr(mkctl(1, 0, 1, 6'(c), 6'(h), 3'(p), 0, 8'h00));
          dat_wr(64'h0);
          priv_win(n);
          settle();
          elo = eva[c] ? 32'(n) : 32'h0;
          ehi = eva[h] ? 32'(n) : 32'h0;
          check("R6 code sweep", dat_rdata, {ehi, elo});
        end
      end
    end
    ev_ext = '0;
    insn_retire = 1'b0;

    // R7: mode gating, all combinations
    for (int m = 0; m < 8; m++) begin
      logic sy, us, pr;
      logic [31:0] e;
      sy = m[0]; us = m[1]; pr = m[2];
      ctl_wr(mkctl(sy, us, 1, 6'd2, 6'd3, 3'd1, 0, 8'h00));
      priv_mode = pr;
      dat_wr(64'h0);
      ev_win(4, 62'h3);
      priv_mode = 1'b0;
      settle();
      e = ((pr && sy) || (!pr && us)) ? 32'd4 : 32'd0;
      check("R7 mode gate", dat_rdata, {e, e});
    end

    // R8: wrap sets sticky flags
    ctl_wr(mkctl(1, 0, 1, 6'd0, 6'd0, 3'd3, 1, 8'h00));
    dat_wr({32'hFFFF_FFFF, 32'hFFFF_FFFE});
    priv_win(3);
    settle();
    m_ovf = 8'hC0;
    check("R8 wrapped values", dat_rdata, {32'd2, 32'd1});
    check("R8 flags set", ctl_rdata, exp_ctl());
    priv_win(2);
    settle();
    check("R8 flags sticky", {56'h0, ctl_rdata[39:32]}, 64'hC0);

    // R9: write wins over increment and over wrap
    ctl_wr(mkctl(1, 0, 1, 6'd0, 6'd0, 3'd0, 1, 8'h00));
    @(negedge clk); priv_mode = 1'b1; dat_we = 1'b1;
    dat_wdata = {32'h0000_1234, 32'h0000_ABCD};
    @(negedge clk); priv_mode = 1'b0; dat_we = 1'b0;
    settle();
    check("R9 write beats increment", dat_rdata, {32'h0000_1234, 32'h0000_ABCD});
    dat_wr('1);
    @(negedge clk); priv_mode = 1'b1; dat_we = 1'b1;
    dat_wdata = {32'd5, 32'd6};
    @(negedge clk); priv_mode = 1'b0; dat_we = 1'b0;
    settle();
    check("R9 write beats wrap value", dat_rdata, {32'd5, 32'd6});
    check("R9 no flag on collided wrap", {56'h0, ctl_rdata[39:32]}, 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule